// File: doc/BRIEF.md
# External Asynchronous Memory Bus Controller

This block sits between an internal request port and an external asynchronous memory bus. Each request carries a byte address, a direction, a size (byte or halfword) and write data. The block compares the top address bits with the base of every enabled chip select and picks one. It then drives one external cycle, or two, with active-low chip select, read strobe, write strobe and byte-lane strobes. When the cycle is over it returns a one-cycle done pulse, and for reads the read data.

Each chip select has its own settings: a base, a data width of 8 or 16 bits, a 3-bit wait-state count, an early or standard read strobe, and a 2-bit count of idle cycles to leave after a read so the external device can release the data bus. An active-low wait input, sampled on rising clock edges, stretches a cycle beyond its programmed wait states. A halfword request to an 8-bit chip select becomes two byte cycles, low byte first. A request that selects no chip select finishes at once with an error flag.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset every chip select, `xrd_n`, `xwr_n`, `xub_n` and `xlb_a0_n` are high, `xd_oe`, `done` and `err` are low, and `rdy` is high.
- R2: A request is taken on a rising edge where `req` and `rdy` are both high. The chip select used is the lowest index i that has `cfg_en[i]` set and `cfg_base[i]` equal to address bits [25:24]. During the access only that chip select is low, and `rdy` stays low.
- R3: A request that matches no enabled chip select raises `done` and `err` for the one cycle after the accepting edge. No chip select or strobe goes low.
- R4: A write with 0 wait states pulls `xwr_n` low only in the first half of the cycle after the accepting edge. `done` is high in the following cycle. The wait input has no effect on this write.
- R5: A write with n wait states (n from 1 to 7) holds `xwr_n` low for n full cycles from the accepting edge, then holds address and chip select for one more cycle before `done`.
- R6: A standard read with n wait states holds `xrd_n` low from the first rising edge after the accepting edge for n+1 cycles. One hold cycle follows, so one byte cycle lasts n+3 cycles.
- R7: An early read also pulls `xrd_n` low in the second half of the first cycle, starting at the falling edge.
- R8: When `xwait_n` is low at a rising edge that would otherwise end the strobe, the strobe and the cycle are stretched by one full cycle for each such edge.
- R9: `xa` carries byte-address bits [23:1]. On a 16-bit chip select, `xlb_a0_n` is low for a halfword or an even byte and `xub_n` is low for a halfword or an odd byte. On an 8-bit chip select, `xlb_a0_n` carries address bit 0 and `xub_n` stays high. Halfword addresses are treated as even.
- R10: During a write `xd_oe` is high. A 16-bit halfword drives `req_wdata` unchanged. Every other beat drives its byte on both lanes: `req_wdata[7:0]`, or `req_wdata[15:8]` for the second beat of a split halfword.
- R11: A halfword request to an 8-bit chip select runs two byte cycles, at the even address and then at the odd address. `done` comes only after the second cycle, and a read returns `{high byte, low byte}`.
- R12: After a read, `rdy` stays low for the chip select's float count (0 to 3) of cycles after the cycle in which `done` is high. After a write there are no float cycles.
- R13: Address and chip select do not change on the rising edge that follows a cycle in which either strobe was low.
- R14: `done` is a one-cycle pulse. With it, `rdata` holds the halfword read, or `{8'h00, byte}` for a byte read. A byte on a 16-bit bus is taken from bits [15:8] when the address is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_hw | input | 1 | 1 = halfword, 0 = byte |
| req_addr | input | 26 | Byte address |
| req_wdata | input | 16 | Write data |
| rdy | output | 1 | Ready to take a request |
| done | output | 1 | Completion pulse |
| err | output | 1 | Request matched no chip select (with done) |
| rdata | output | 16 | Read data |
| cfg_en | input | 4 | Per-chip-select enable |
| cfg_base | input | 8 | Per-chip-select 2-bit base |
| cfg_wide | input | 4 | Per-chip-select 16-bit bus |
| cfg_early | input | 4 | Per-chip-select early read strobe |
| cfg_ws | input | 12 | Per-chip-select 3-bit wait-state count |
| cfg_flt | input | 8 | Per-chip-select 2-bit float count |
| xcs_n | output | 4 | Chip selects, active low |
| xrd_n | output | 1 | Read strobe, active low |
| xwr_n | output | 1 | Write strobe, active low |
| xub_n | output | 1 | Upper byte strobe, active low |
| xlb_a0_n | output | 1 | Lower byte strobe, or address bit 0 on 8-bit chip selects |
| xa | output | 23 | Halfword address, bits [23:1] |
| xd_o | output | 16 | Data bus out |
| xd_oe | output | 1 | Data bus output enable |
| xd_i | input | 16 | Data bus in |
| xwait_n | input | 1 | External wait, active low |

## Verification
Two things can land on the same rising edge. One is the edge where the wait input is sampled and the strobe would end. The other is a beat boundary in a split halfword, where the second byte cycle starts on the same edge that ends the first. The bench pulls `xwait_n` low across the edges that end the strobe, on a split halfword write to an 8-bit chip select with wait states, and on reads with and without the early strobe. Its behavioural model predicts every half cycle: strobe levels, address, lane strobes and data. It checks that each beat is stretched by exactly the number of low samples and that the second beat begins only after the stretched first beat has closed.

// File: rtl/xbus_ctrl.sv
`timescale 1ns/1ps
module xbus_ctrl #(
  parameter int NCS     = 4,
  parameter int AW      = 26,
  parameter int REG_LG2 = 24,
  parameter int WSW     = 3,
  parameter int FLW     = 2
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic                 req_we,
  input  logic                 req_hw,
  input  logic [AW-1:0]        req_addr,
  input  logic [15:0]          req_wdata,
  output logic                 rdy,
  output logic                 done,
  output logic                 err,
  output logic [15:0]          rdata,
  input  logic [NCS-1:0]       cfg_en,
  input  logic [NCS*(AW-REG_LG2)-1:0] cfg_base,
  input  logic [NCS-1:0]       cfg_wide,
  input  logic [NCS-1:0]       cfg_early,
  input  logic [NCS*WSW-1:0]   cfg_ws,
  input  logic [NCS*FLW-1:0]   cfg_flt,
  output logic [NCS-1:0]       xcs_n,
  output logic                 xrd_n,
  output logic                 xwr_n,
  output logic                 xub_n,
  output logic                 xlb_a0_n,
  output logic [REG_LG2-2:0]   xa,
  output logic [15:0]          xd_o,
  output logic                 xd_oe,
  input  logic [15:0]          xd_i,
  input  logic                 xwait_n
);
  localparam int BW   = AW - REG_LG2;
  localparam int CW   = (NCS > 1) ? $clog2(NCS) : 1;
  localparam int CNTW = WSW + 1;

  logic          hit;
  logic [CW-1:0] hit_idx;
  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = NCS - 1; i >= 0; i--)
      if (cfg_en[i] && req_addr[AW-1:REG_LG2] == cfg_base[i*BW +: BW]) begin
        hit = 1'b1;
        hit_idx = CW'(i);
      end
  end

  wire [WSW-1:0] sel_ws  = cfg_ws[hit_idx*WSW +: WSW];
  wire [FLW-1:0] sel_flt = cfg_flt[hit_idx*FLW +: FLW];

  logic              acc, we_q, hw_q, wide_q, early_q, fst, beat, tog, ntog;
  logic              done_q, err_q;
  logic [CW-1:0]     cs_q;
  logic [REG_LG2-1:0] a_q;
  logic [WSW-1:0]    ws_q;
  logic [FLW-1:0]    flt_q, fcnt;
  logic [CNTW-1:0]   cnt;
  logic [15:0]       wd_q, rbuf;

  wire [REG_LG2-1:0] ea = {a_q[REG_LG2-1:1], a_q[0] | beat};
  wire last_beat = !(hw_q && !wide_q) || beat;
  wire half = (tog == ntog);
  wire [CNTW-1:0] reload = we_q ? CNTW'(ws_q) : CNTW'(ws_q) + CNTW'(2);

  assign rdy = !acc && (fcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= 1'b0; we_q <= 1'b0; hw_q <= 1'b0; wide_q <= 1'b0; early_q <= 1'b0;
      fst <= 1'b0; beat <= 1'b0; tog <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      cs_q <= '0; a_q <= '0; ws_q <= '0; flt_q <= '0; fcnt <= '0; cnt <= '0;
      wd_q <= '0; rbuf <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      fst    <= 1'b0;
      if (!acc) begin
        if (fcnt != '0) fcnt <= fcnt - 1'b1;
        if (req && rdy) begin
          if (hit) begin
            acc     <= 1'b1;
            fst     <= 1'b1;
            tog     <= ~tog;
            beat    <= 1'b0;
            cs_q    <= hit_idx;
            a_q     <= req_hw ? {req_addr[REG_LG2-1:1], 1'b0} : req_addr[REG_LG2-1:0];
            we_q    <= req_we;
            hw_q    <= req_hw;
            wide_q  <= cfg_wide[hit_idx];
            early_q <= cfg_early[hit_idx];
            ws_q    <= sel_ws;
            flt_q   <= sel_flt;
            wd_q    <= req_wdata;
            cnt     <= req_we ? CNTW'(sel_ws) : CNTW'(sel_ws) + CNTW'(2);
          end else begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end
        end
      end else if (cnt != '0) begin
        if (!(cnt == CNTW'(1) && !xwait_n)) cnt <= cnt - 1'b1;
        if (cnt == CNTW'(1) && xwait_n && !we_q) begin
          if (wide_q)
            rbuf <= hw_q ? xd_i : {8'h00, ea[0] ? xd_i[15:8] : xd_i[7:0]};
          else if (beat)
            rbuf[15:8] <= xd_i[7:0];
          else
            rbuf <= {8'h00, xd_i[7:0]};
        end
      end else if (!last_beat) begin
        beat <= 1'b1;
        fst  <= 1'b1;
        tog  <= ~tog;
        cnt  <= reload;
      end else begin
        acc    <= 1'b0;
        done_q <= 1'b1;
        if (!we_q) fcnt <= flt_q;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ntog <= 1'b0;
    else        ntog <= tog;
  end

  wire [7:0] wb = (hw_q && beat) ? wd_q[15:8] : wd_q[7:0];

  assign done     = done_q;
  assign err      = err_q;
  assign rdata    = rbuf;
  assign xcs_n    = acc ? ~(NCS'(1) << cs_q) : '1;
  assign xa       = ea[REG_LG2-1:1];
  assign xlb_a0_n = !acc ? 1'b1 : (wide_q ? !(hw_q || !ea[0]) : ea[0]);
  assign xub_n    = !(acc && wide_q && (hw_q || ea[0]));
  assign xd_oe    = acc && we_q;
  assign xd_o     = (wide_q && hw_q) ? wd_q : {wb, wb};
  assign xwr_n    = !(acc && we_q && ((ws_q == '0) ? !half : (cnt != '0)));
  assign xrd_n    = !(acc && !we_q && (cnt != '0) && (early_q ? (half || !fst) : !fst));
endmodule

// File: rtl/xbus_ctrl_chk.sv
`timescale 1ns/1ps
module xbus_ctrl_chk #(
  parameter int NCS = 4,
  parameter int XAW = 23
)(
  input logic           clk,
  input logic           rst_n,
  input logic [NCS-1:0] xcs_n,
  input logic           xrd_n,
  input logic           xwr_n,
  input logic [XAW-1:0] xa,
  input logic           done,
  input logic           err,
  input logic           rdy
);
  p_one_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~xcs_n));

  p_strobe_has_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!xrd_n || !xwr_n) |-> !(&xcs_n));

  p_err_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> ((&xcs_n) && xrd_n && xwr_n));

  p_hold_after_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!xrd_n || !xwr_n) |=> ($stable(xa) && $stable(xcs_n)));

  p_busy_not_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(&xcs_n) |-> !rdy);
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.NCS(NCS), .XAW(REG_LG2-1)) u_chk (
  .clk(clk), .rst_n(rst_n), .xcs_n(xcs_n), .xrd_n(xrd_n), .xwr_n(xwr_n),
  .xa(xa), .done(done), .err(err), .rdy(rdy)
);

// File: tb/xbus_ctrl_bench.sv
`timescale 1ns/1ps
module xbus_ctrl_bench;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic req = 0, req_we = 0, req_hw = 0;
  logic [25:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic rdy, done, err;
  logic [15:0] rdata;
  logic [3:0] cfg_en, cfg_wide, cfg_early;
  logic [7:0] cfg_base, cfg_flt;
  logic [11:0] cfg_ws;
  logic [3:0] xcs_n;
  logic xrd_n, xwr_n, xub_n, xlb_a0_n, xd_oe;
  logic [22:0] xa;
  logic [15:0] xd_o, xd_i;
  logic xwait_n = 1;

  logic       c_en[4], c_wide[4], c_early[4];
  logic [1:0] c_base[4], c_flt[4];
  logic [2:0] c_ws[4];
  logic       cur_wide = 1;

  always_comb
    for (int i = 0; i < 4; i++) begin
      cfg_en[i] = c_en[i];
      cfg_wide[i] = c_wide[i];
      cfg_early[i] = c_early[i];
      cfg_base[i*2 +: 2] = c_base[i];
      cfg_flt[i*2 +: 2] = c_flt[i];
      cfg_ws[i*3 +: 3] = c_ws[i];
    end

  function automatic logic [7:0] bv(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  always_comb
    xd_i = cur_wide ? {bv({xa[6:0], 1'b1}), bv({xa[6:0], 1'b0})}
                    : {8'hEE, bv({xa[6:0], xlb_a0_n})};

  xbus_ctrl u_xbus_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_hw(req_hw),
    .req_addr(req_addr), .req_wdata(req_wdata), .rdy(rdy), .done(done), .err(err),
    .rdata(rdata), .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_wide(cfg_wide),
    .cfg_early(cfg_early), .cfg_ws(cfg_ws), .cfg_flt(cfg_flt), .xcs_n(xcs_n),
    .xrd_n(xrd_n), .xwr_n(xwr_n), .xub_n(xub_n), .xlb_a0_n(xlb_a0_n), .xa(xa),
    .xd_o(xd_o), .xd_oe(xd_oe), .xd_i(xd_i), .xwait_n(xwait_n)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic txn(input string tag, input bit we, input bit hw, input logic [25:0] a,
                     input logic [15:0] wd, input int xw);
    int cs = -1;
    int nb, lb0, x, lb;
    bit wide, early;
    int ws, flt;
    logic [25:0] ea0, ea;
    logic [7:0] bb;
    for (int i = 3; i >= 0; i--)
      if (c_en[i] && c_base[i] == a[25:24]) cs = i;
    @(negedge clk);
    while (!rdy) @(negedge clk);
    req = 1; req_we = we; req_hw = hw; req_addr = a; req_wdata = wd;
    if (cs >= 0) cur_wide = c_wide[cs];
    @(posedge clk); #1 req = 0;
    if (cs < 0) begin
      #1;
      chk(tag, "err done", {31'd0, done}, 1);
      chk(tag, "err flag", {31'd0, err}, 1);
      chk(tag, "err cs", {28'd0, xcs_n}, 32'hF);
      chk(tag, "err strobes", {30'd0, xrd_n, xwr_n}, 3);
      @(negedge clk); #1;
      chk(tag, "err strobes late", {26'd0, xcs_n, xrd_n, xwr_n}, 32'h3F);
      @(posedge clk); #1;
      return;
    end
    wide = c_wide[cs]; early = c_early[cs]; ws = c_ws[cs]; flt = c_flt[cs];
    nb = (hw && !wide) ? 2 : 1;
    ea0 = hw ? {a[25:1], 1'b0} : a;
    for (int b = 0; b < nb; b++) begin
      ea = ea0 | 26'(b);
      lb0 = we ? ((ws == 0) ? 1 : ws + 1) : ws + 3;
      x = (we && ws == 0) ? 0 : xw;
      lb = lb0 + x;
      bb = (hw && b == 1) ? wd[15:8] : wd[7:0];
      for (int k = 0; k < lb; k++) begin
        #1;
        chk(tag, "cs", {28'd0, xcs_n}, {28'd0, ~(4'd1 << cs)});
        chk(tag, "wr ph0", {31'd0, xwr_n},
            {31'd0, !(we && ((ws == 0) ? (k == 0) : (k < lb0 - 1 + x)))});
        chk(tag, "rd ph0", {31'd0, xrd_n}, {31'd0, !(!we && k >= 1 && k <= lb - 2)});
        chk(tag, "busy", {30'd0, done, rdy}, 0);
        chk(tag, "xa", {9'd0, xa}, {9'd0, ea[23:1]});
        chk(tag, "lb/a0", {31'd0, xlb_a0_n}, {31'd0, wide ? !(hw || !ea[0]) : ea[0]});
        chk(tag, "ub", {31'd0, xub_n}, {31'd0, wide ? !(hw || ea[0]) : 1'b1});
        chk(tag, "oe", {31'd0, xd_oe}, {31'd0, we});
        if (we) chk(tag, "wdata", {16'd0, xd_o}, {16'd0, (wide && hw) ? wd : {bb, bb}});
        @(negedge clk); #1;
        chk(tag, "wr ph1", {31'd0, xwr_n},
            {31'd0, !(we && ws != 0 && k < lb0 - 1 + x)});
        chk(tag, "rd ph1", {31'd0, xrd_n},
            {31'd0, !(!we && ((k >= 1 && k <= lb - 2) || (early && k == 0)))});
        xwait_n = !(x > 0 && k >= lb0 - 2 && k <= lb0 + x - 3);
        @(posedge clk); #1;
      end
    end
    #1;
    chk(tag, "done", {31'd0, done}, 1);
    chk(tag, "no err", {31'd0, err}, 0);
    chk(tag, "cs idle", {28'd0, xcs_n}, 32'hF);
    if (!we)
      chk(tag, "rdata", {16'd0, rdata},
          {16'd0, hw ? {bv({ea0[7:1], 1'b1}), bv({ea0[7:1], 1'b0})} : {8'h00, bv(a[7:0])}});
    if (we) chk(tag, "R12 no float after write", {31'd0, rdy}, 1);
    else
      for (int j = 0; j <= flt; j++) begin
        if (j > 0) begin @(posedge clk); #2; end
        chk("R12", "float rdy", {31'd0, rdy}, {31'd0, j == flt});
      end
  endtask

  initial begin
    #2000000;
    nfail++; nchk++;
    $display("FAIL R1 watchdog act=hung exp=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    c_en = '{1, 1, 1, 0};
    c_base = '{2'd0, 2'd1, 2'd2, 2'd3};
    c_wide = '{1, 0, 1, 0};
    c_early = '{0, 1, 1, 0};
    c_ws = '{3'd2, 3'd0, 3'd0, 3'd3};
    c_flt = '{2'd1, 2'd0, 2'd2, 2'd0};
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "reset cs", {28'd0, xcs_n}, 32'hF);
    chk("R1", "reset strobes", {28'd0, xrd_n, xwr_n, xub_n, xlb_a0_n}, 32'hF);
    chk("R1", "reset oe/done/err", {29'd0, xd_oe, done, err}, 0);
    chk("R1", "reset rdy", {31'd0, rdy}, 1);
    rst_n = 1;

    txn("R5", 1, 1, 26'h000_1234, 16'hA5C3, 0);
    txn("R6", 0, 1, 26'h000_1234, 16'h0, 0);
    txn("R14", 0, 0, 26'h000_0457, 16'h0, 0);
    txn("R9", 0, 0, 26'h000_0456, 16'h0, 0);
    txn("R4", 1, 0, 26'h200_0011, 16'h003C, 0);
    txn("R8", 1, 0, 26'h200_0020, 16'h0077, 2);
    txn("R7", 0, 1, 26'h200_0040, 16'h0, 0);
    txn("R11", 0, 1, 26'h100_0062, 16'h0, 0);
    txn("R11", 1, 1, 26'h100_0070, 16'hBEEF, 0);
    txn("R10", 1, 0, 26'h100_0083, 16'h12D4, 0);
    txn("R8", 0, 1, 26'h000_0090, 16'h0, 3);
    txn("R8", 0, 0, 26'h100_0031, 16'h0, 1);
    txn("R3", 0, 1, 26'h300_0000, 16'h0, 0);
    txn("R3", 1, 0, 26'h3FF_FFFF, 16'h1, 0);
    c_en[3] = 1; c_base[3] = 2'd0;
    txn("R2", 1, 0, 26'h000_00A0, 16'h0055, 0);
    c_base[3] = 2'd3;
    txn("R11", 1, 1, 26'h300_0100, 16'hC0DE, 1);
    txn("R11", 0, 1, 26'h300_0100, 16'h0, 2);
    txn("R2", 0, 0, 26'h300_0105, 16'h0, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule